// File: doc/BRIEF.md
# Dual Row-Buffer DRAM Bank Controller

This block fronts one 1 MB DRAM bank that belongs to a single processing element on a ring. Three requesters share the bank: the element that owns it, the neighbour to the north and the neighbour to the south. A round-robin arbiter picks one of them and the controller serves exactly one access at a time. Two row buffers of 1 KB each hold recently used rows. An access to a row held in either buffer is a hit and finishes in 2 cycles. Any other access is a miss: it takes 4 cycles and loads the row into the least-recently-used buffer.

Requests use a valid/ready handshake per port. A requester raises valid with its write flag, byte address and write data and holds all of them stable until the cycle in which its ready is high. Ready can be high for at most one port, and only while the controller is idle. The response cannot be stalled: it is a single-cycle done pulse on the issuing port's bit, with the data word on a shared bus. The bank array is a behavioural model that stores `MODEL_ROWS` distinct rows. Row numbers wrap modulo that count for data storage only. Tag comparison always uses the full 10-bit row number.

Top module: `dram_bank_ctrl`

## Requirements
- R1: Reset clears both buffers to invalid and drives every ready and done bit low. The first access after reset to any row therefore takes the miss latency. Reset leaves the bank array's contents unchanged.
- R2: A 20-bit byte address is decoded as follows: bits [19:10] give the row, bits [9:2] give the 32-bit word within that row, and bits [1:0] are ignored.
- R3: A hit raises done on the second rising edge after the edge that accepts the request.
- R4: A miss raises done on the fourth rising edge after the edge that accepts the request.
- R5: Two different rows can be open at the same time, one in each buffer, and each of them hits.
- R6: A miss refills the buffer whose last use is older. After reset, buffer 0 is refilled first.
- R7: A write updates the bank array in every case, and also updates the buffer copy when the row is held. Later reads, both hits and misses after eviction, return the written word.
- R8: Ports are numbered 0 (own element), 1 (north) and 2 (south). Among the valid ports, the grant goes to the first one after the most recently accepted port in cyclic order. After reset, the search starts at port 0.
- R9: Only one request is in flight at a time. Every ready bit stays low from acceptance until the done cycle, and at most one ready bit is high in any cycle.
- R10: Completion is a done pulse lasting exactly one cycle, on the issuing port's bit only. The data bus carries the addressed word for a read and the written word for a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 3 | Request valid, one bit per port |
| req_ready | output | 3 | Request accepted at this edge, one bit per port |
| req_we | input | 3 | Write flag per port |
| req_addr | input | 60 | Byte address per port, port p in bits [20p+19:20p] |
| req_wdata | input | 96 | Write data per port, port p in bits [32p+31:32p] |
| rsp_valid | output | 3 | Done pulse, one bit per port |
| rsp_rdata | output | 32 | Returned data word, valid with the done pulse |

## Verification
The delicate coincidence is a done pulse for one port landing in the same cycle that the arbiter grants the next waiting port. The controller returns to idle in that cycle while the response register is still being driven. The bench provokes this by raising all three valid bits together while a rotated round-robin pointer is in place. It mixes hits and misses so that the responses close at different latencies. On every cycle it checks the grant order, that ready is low while a request is in flight, the data each port receives, and that exactly two grants coincide with a done pulse.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} dbc_state_e;
  localparam int DBC_N_BUF = 2;
  localparam int PORT_OWN   = 0;
  localparam int PORT_NORTH = 1;
  localparam int PORT_SOUTH = 2;
endpackage

// File: rtl/dbc_rr_arb.sv
module dbc_rr_arb #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx
);
  logic [IW-1:0] last_q;

  always_comb begin
    logic found;
    int   idx;
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        gidx     = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= IW'(N - 1);
    else if (adv) last_q <= gidx;
  end

  // R8
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/dbc_row_buf.sv
module dbc_row_buf #(
  parameter int ROW_W  = 10,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_en,
  input  logic [ROW_W-1:0]             fill_tag,
  input  logic [WORDS-1:0][DATA_W-1:0] fill_row,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         valid,
  output logic [ROW_W-1:0]             tag
);
  logic [WORDS-1:0][DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
    end else if (fill_en) begin
      valid <= 1'b1;
      tag   <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en)    data_q <= fill_row;
    else if (wr_en) data_q[wr_idx] <= wr_data;
  end

  assign rd_data = data_q[rd_idx];

  // R6
  fill_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid && tag == $past(fill_tag)));
endmodule

// File: rtl/dbc_store.sv
module dbc_store #(
  parameter int MODEL_ROWS = 8,
  parameter int IDX_W      = 8,
  parameter int DATA_W     = 32,
  localparam int WORDS = 1 << IDX_W,
  localparam int MR_W  = $clog2(MODEL_ROWS)
) (
  input  logic                         clk,
  input  logic [MR_W-1:0]              row_sel,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [WORDS-1:0][DATA_W-1:0] row_q
);
  logic [WORDS-1:0][DATA_W-1:0] mem [MODEL_ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[row_sel][wr_idx] <= wr_data;
  end

  assign row_q = mem[row_sel];
endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
  import dbc_pkg::*;
#(
  parameter int N_PORTS    = 3,
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 32,
  parameter int ROW_LSB    = 10,
  parameter int WORD_LSB   = 2,
  parameter int MODEL_ROWS = 8,
  parameter int HIT_LAT    = 2,
  parameter int MISS_LAT   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PORTS-1:0]          req_valid,
  output logic [N_PORTS-1:0]          req_ready,
  input  logic [N_PORTS-1:0]          req_we,
  input  logic [N_PORTS*ADDR_W-1:0]   req_addr,
  input  logic [N_PORTS*DATA_W-1:0]   req_wdata,
  output logic [N_PORTS-1:0]          rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata
);
  localparam int IDX_W  = ROW_LSB - WORD_LSB;
  localparam int WORDS  = 1 << IDX_W;
  localparam int ROW_W  = ADDR_W - ROW_LSB;
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int CNT_W  = $clog2(MISS_LAT + 1);
  localparam int MR_W   = $clog2(MODEL_ROWS);

  typedef logic [WORDS-1:0][DATA_W-1:0] row_t;

  dbc_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic               lru;
  logic [PORT_W-1:0]  cur_port;
  logic               cur_we;
  logic [ROW_W-1:0]   cur_row;
  logic [IDX_W-1:0]   cur_idx;
  logic [DATA_W-1:0]  cur_wdata;

  logic [N_PORTS-1:0] gnt;
  logic [PORT_W-1:0]  gidx;
  logic               idle, accept, finish, hit, hit_sel;
  logic [CNT_W-1:0]   need;
  logic [ADDR_W-1:0]  sel_addr;

  logic [DBC_N_BUF-1:0] buf_valid, hit_vec, fill_en, wr_en;
  logic [ROW_W-1:0]     buf_tag [DBC_N_BUF];
  logic [DATA_W-1:0]    buf_rd  [DBC_N_BUF];
  row_t                 store_row, merged_row;

  assign idle      = (state == ST_IDLE);
  assign accept    = idle && (|gnt);
  assign req_ready = idle ? gnt : '0;
  assign sel_addr  = req_addr[int'(gidx)*ADDR_W +: ADDR_W];

  dbc_rr_arb #(.N(N_PORTS)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_valid),
    .adv  (accept),
    .gnt  (gnt),
    .gidx (gidx)
  );

  dbc_store #(.MODEL_ROWS(MODEL_ROWS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .row_sel(cur_row[MR_W-1:0]),
    .wr_en  (finish && cur_we),
    .wr_idx (cur_idx),
    .wr_data(cur_wdata),
    .row_q  (store_row)
  );

  always_comb begin
    merged_row = store_row;
    if (cur_we) merged_row[cur_idx] = cur_wdata;
  end

  for (genvar b = 0; b < DBC_N_BUF; b++) begin : g_buf
    assign hit_vec[b] = buf_valid[b] && (buf_tag[b] == cur_row);
    assign fill_en[b] = finish && !hit && (int'(lru) == b);
    assign wr_en[b]   = finish && hit && cur_we && (int'(hit_sel) == b);

    dbc_row_buf #(.ROW_W(ROW_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rb (
      .clk     (clk),
      .rst_n   (rst_n),
      .fill_en (fill_en[b]),
      .fill_tag(cur_row),
      .fill_row(merged_row),
      .wr_en   (wr_en[b]),
      .wr_idx  (cur_idx),
      .wr_data (cur_wdata),
      .rd_idx  (cur_idx),
      .rd_data (buf_rd[b]),
      .valid   (buf_valid[b]),
      .tag     (buf_tag[b])
    );
  end

  assign hit     = |hit_vec;
  assign hit_sel = hit_vec[1];
  assign need    = hit ? CNT_W'(HIT_LAT - 1) : CNT_W'(MISS_LAT - 1);
  assign finish  = (state == ST_BUSY) && (cnt == need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      lru       <= 1'b0;
      cur_port  <= '0;
      cur_we    <= 1'b0;
      cur_row   <= '0;
      cur_idx   <= '0;
      cur_wdata <= '0;
      rsp_valid <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= '0;
      case (state)
        ST_IDLE: if (accept) begin
          cur_port  <= gidx;
          cur_we    <= req_we[gidx];
          cur_row   <= sel_addr[ADDR_W-1:ROW_LSB];
          cur_idx   <= sel_addr[ROW_LSB-1:WORD_LSB];
          cur_wdata <= req_wdata[int'(gidx)*DATA_W +: DATA_W];
          cnt       <= '0;
          state     <= ST_BUSY;
        end
        default: if (finish) begin
          rsp_valid <= N_PORTS'(1) << cur_port;
          if (cur_we)   rsp_rdata <= cur_wdata;
          else if (hit) rsp_rdata <= buf_rd[hit_sel];
          else          rsp_rdata <= store_row[cur_idx];
          lru   <= hit ? ~hit_sel : ~lru;
          state <= ST_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R9
  one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |-> (req_ready == '0));

  // R10
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |=> (rsp_valid == '0));

  // R5
  distinct_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&buf_valid) |-> (buf_tag[0] != buf_tag[1]));
endmodule

// File: tb/dram_bank_ctrl_bench.sv
module dram_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  typedef struct packed {
    logic [1:0]  port;
    logic        we;
    logic [19:0] addr;
    logic [31:0] wdata;
    logic [31:0] expd;
    logic [2:0]  lat;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, {10'd1, 8'd5, 2'd0}, 32'h11110001, 32'h11110001, 3'd4},
    '{2'd0, 1'b0, {10'd1, 8'd5, 2'd0}, 32'h0,        32'h11110001, 3'd2},
    '{2'd1, 1'b1, {10'd2, 8'd7, 2'd0}, 32'h22220002, 32'h22220002, 3'd4},
    '{2'd2, 1'b0, {10'd1, 8'd5, 2'd1}, 32'h0,        32'h11110001, 3'd2},
    '{2'd0, 1'b0, {10'd2, 8'd7, 2'd3}, 32'h0,        32'h22220002, 3'd2},
    '{2'd0, 1'b1, {10'd3, 8'd0, 2'd0}, 32'h33330003, 32'h33330003, 3'd4},
    '{2'd1, 1'b0, {10'd2, 8'd7, 2'd0}, 32'h0,        32'h22220002, 3'd2},
    '{2'd2, 1'b0, {10'd1, 8'd5, 2'd0}, 32'h0,        32'h11110001, 3'd4},
    '{2'd1, 1'b1, {10'd1, 8'd5, 2'd0}, 32'h44440004, 32'h44440004, 3'd2},
    '{2'd0, 1'b0, {10'd2, 8'd7, 2'd0}, 32'h0,        32'h22220002, 3'd2},
    '{2'd2, 1'b0, {10'd3, 8'd0, 2'd0}, 32'h0,        32'h33330003, 3'd4},
    '{2'd0, 1'b0, {10'd1, 8'd5, 2'd0}, 32'h0,        32'h44440004, 3'd4},
    '{2'd1, 1'b0, {10'd3, 8'd0, 2'd0}, 32'h0,        32'h33330003, 3'd2}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0;
  logic [NP-1:0]    req_ready;
  logic [NP-1:0]    req_we = '0;
  logic [NP*20-1:0] req_addr = '0;
  logic [NP*32-1:0] req_wdata = '0;
  logic [NP-1:0]    rsp_valid;
  logic [31:0]      rsp_rdata;

  int checks = 0;
  int errors = 0;

  dram_bank_ctrl u_dram_bank_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_req(input int p, input bit we, input logic [19:0] a,
                         input logic [31:0] wd, input logic [31:0] expd,
                         input int exp_lat);
    int lat;
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_we[p] = we;
    req_addr[p*20 +: 20] = a;
    req_wdata[p*32 +: 32] = wd;
    #1;
    while (!req_ready[p]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[p] = 1'b0;
    lat = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (|rsp_valid) break;
    end
    check(lat == exp_lat, (exp_lat == 2) ? "R3" : "R4", "latency", lat, exp_lat);
    check(rsp_valid == NP'(1) << p, "R10", "done port", rsp_valid, NP'(1) << p);
    check(rsp_rdata == expd, "R7", "data", rsp_rdata, expd);
    @(negedge clk);
    check(rsp_valid == '0, "R10", "pulse width", rsp_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ord[3];
    int exp_ord[3];
    logic [31:0] exp_dat[3];
    int ng, nrsp, pend, coinc;
    bit inflight, rsp_now;

    do_reset();
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == '0, "R1", "done after reset", rsp_valid, 0);
    check(req_ready == '0, "R1", "ready after reset", req_ready, 0);

    // vector table: R2 R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++)
      run_req(int'(VEC[i].port), VEC[i].we, VEC[i].addr, VEC[i].wdata,
              VEC[i].expd, int'(VEC[i].lat));

    // R1: buffered row is a miss after reset, array contents kept
    do_reset();
    run_req(1, 1'b0, {10'd3, 8'd0, 2'd0}, 32'h0, 32'h33330003, 4);

    // R8 R9: all three ports at once, pointer at port 1
    exp_ord = '{2, 0, 1};
    exp_dat = '{32'h44440004, 32'h22220002, 32'h33330003};
    @(negedge clk);
    req_we = '0;
    req_addr = {{10'd3, 8'd0, 2'd0}, {10'd2, 8'd7, 2'd0}, {10'd1, 8'd5, 2'd0}};
    req_valid = 3'b111;
    ng = 0; nrsp = 0; pend = -1; coinc = 0; inflight = 1'b0;
    for (int cyc = 0; cyc < 40 && nrsp < 3; cyc++) begin
      #1;
      rsp_now = |rsp_valid;
      if (rsp_now) begin
        check(rsp_valid == NP'(1) << exp_ord[nrsp], "R8", "response order",
              rsp_valid, NP'(1) << exp_ord[nrsp]);
        check(rsp_rdata == exp_dat[exp_ord[nrsp]], "R10", "contended data",
              rsp_rdata, exp_dat[exp_ord[nrsp]]);
        inflight = 1'b0;
        nrsp++;
      end
      if (inflight) check(req_ready == '0, "R9", "ready while busy", req_ready, 0);
      if ((req_ready & req_valid) != '0) begin
        check($countones(req_ready) == 1, "R9", "single ready", req_ready, 1);
        for (int q = 0; q < NP; q++)
          if (req_ready[q] && ng < 3) begin
            ord[ng] = q;
            pend = q;
          end
        ng++;
        inflight = 1'b1;
        if (rsp_now) coinc++;
      end
      @(posedge clk);
      @(negedge clk);
      if (pend >= 0) begin
        req_valid[pend] = 1'b0;
        pend = -1;
      end
    end
    for (int j = 0; j < 3; j++)
      check(ord[j] == exp_ord[j], "R8", "grant order", ord[j], exp_ord[j]);
    check(coinc == 2, "R9", "grant in done cycle", coinc, 2);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule